// File: doc/BRIEF.md
# Event-Synchronized Shadow Register Bank

This block holds the control registers of a video scaling path in two copies. The host writes over a simple bus of address, data and write strobe, and each write lands in a staging copy. A second, active copy drives the datapath. The active copy takes the staged value only when the video event assigned to that register occurs. As a result, a scale factor, clip setting or format field never changes in the middle of the field, window or line that it governs.

Five timing inputs are registered into the core clock and turned into one-cycle event pulses:
- a vertical pulse from each of the two input ports, on the edge chosen by the static register;
- the end of the vertical gate of the second processing unit;
- the end of the vertical gate of the first processing unit, which marks the end of a window;
- the start of the horizontal gate of the first processing unit, which begins a line.

Each register address belongs to one of these event classes. One register holds static settings, has no event and takes effect as soon as it is written. A pending bit per register shows that a staged value is still waiting for its event.

Top module: `shadow_upload`

## Requirements
- R1: After reset, every staging copy, every active copy and every pending bit is zero, and all event and hazard outputs are low.
- R2: A write to offset 0x50 (the static register, index 0) appears on its active output after the writing clock edge. It never sets a pending bit.
- R3: `staticHazard` is high for exactly one cycle after a write to 0x50 made while `procEn` is high. A write to 0x50 made while `procEn` is low leaves it low.
- R4: Offset 0x54 (index 1) commits on an edge of `vsA`. Static bit 0 selects the edge: 0 means rising, 1 means falling.
- R5: Offset 0x58 (index 2) commits on an edge of `vsB`. Static bit 1 selects the edge: 0 means rising, 1 means falling.
- R6: Offset 0x5C (index 3) commits on the falling edge of `vGate2`.
- R7: Offsets 0x60, 0x64, 0x74 and 0x78 (indices 4, 5, 8 and 9) commit on the falling edge of `vGate1`, the end of a window.
- R8: Offsets 0x68 and 0x6C (indices 6 and 7) commit on the rising edge of `hGate1`, the start of a line.
- R9: Each event output is a one-cycle pulse. It is high in the cycle after the clock edge that samples the input edge. The commit happens at the clock edge that ends that pulse. An input edge that does not belong to a register's class leaves that register's active copy unchanged.
- R10: When a host write lands in the same cycle as its register's event, the active copy takes the previously staged value. The new value stays pending and commits on the next event.
- R11: A write sets the register's pending bit (bit i for index i). A commit clears it.
- R12: `rdData` returns the staging copy of the addressed register. A write to an unmapped offset (for example 0x70) changes nothing, and a read of it returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| procEn | input | 1 | High while cyclic video processing runs |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | AW | Host write byte offset |
| wrData | input | DW | Host write data |
| rdAddr | input | AW | Host read byte offset |
| rdData | output | DW | Staging value at rdAddr, zero if unmapped |
| vsA | input | 1 | Vertical blanking pulse, input port A |
| vsB | input | 1 | Vertical blanking pulse, input port B |
| vGate2 | input | 1 | Vertical gate output of processing unit 2 |
| vGate1 | input | 1 | Vertical gate output of processing unit 1 |
| hGate1 | input | 1 | Horizontal gate output of processing unit 1 |
| activeFlat | output | NREG*DW | Active copies; index i at bits [i*DW +: DW] |
| pending | output | NREG | Pending bit per register index |
| evtPortA | output | 1 | Port A commit event pulse |
| evtPortB | output | 1 | Port B commit event pulse |
| evtUnit2Done | output | 1 | Unit 2 done event pulse |
| evtWindowDone | output | 1 | Window done event pulse |
| evtLineDone | output | 1 | Line start event pulse |
| staticHazard | output | 1 | Static register written during processing |

## Verification
The assertions assume that the timing inputs are synchronous to the core clock and that each level lasts at least two cycles. Under that assumption every edge yields exactly one event pulse. The bench changes each timing input on the falling clock edge and holds the new level for at least two cycles. It also times the collision case so that the host write and the event pulse meet at the same rising edge. Host write strobes last one cycle and are never back to back with an event on the same input.

// File: rtl/shadow_upload_pkg.sv
package shadow_upload_pkg;
  localparam int NREG = 10;
  localparam int NSRC = 5;

  typedef enum logic [2:0] {
    EV_NONE, EV_PORTA, EV_PORTB, EV_UNIT2, EV_WINDOW, EV_LINE
  } evClass_e;

  // byte offset of register index
  function automatic logic [7:0] regOffset(int idx);
    if (idx < 8) return 8'(8'h50 + 4 * idx);
    return 8'(8'h74 + 4 * (idx - 8));
  endfunction

  function automatic evClass_e regClass(int idx);
    case (idx)
      0:       return EV_NONE;
      1:       return EV_PORTA;
      2:       return EV_PORTB;
      3:       return EV_UNIT2;
      6, 7:    return EV_LINE;
      default: return EV_WINDOW;
    endcase
  endfunction

  typedef struct packed {
    logic [NREG-1:0] wrSel;
    logic [NREG-1:0] commit;
  } strobe_t;
endpackage

// File: rtl/shadow_upload_ctrl.sv
module shadow_upload_ctrl
  import shadow_upload_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            procEn,
  input  logic            wrEn,
  input  logic [AW-1:0]   wrAddr,
  input  logic [NSRC-1:0] rawSync,
  input  logic [1:0]      edgeSel,
  output strobe_t         strobe,
  output logic [NSRC-1:0] evt,
  output logic            staticHazard
);
  logic [NSRC-1:0] syncQ, prevQ, riseEv, fallEv;

  for (genvar s = 0; s < NSRC; s++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ[s] <= 1'b0;
        prevQ[s] <= 1'b0;
      end else begin
        syncQ[s] <= rawSync[s];
        prevQ[s] <= syncQ[s];
      end
    end
    assign riseEv[s] = syncQ[s] & ~prevQ[s];
    assign fallEv[s] = ~syncQ[s] & prevQ[s];
  end

  always_comb begin
    evt[0] = edgeSel[0] ? fallEv[0] : riseEv[0];
    evt[1] = edgeSel[1] ? fallEv[1] : riseEv[1];
    evt[2] = fallEv[2];
    evt[3] = fallEv[3];
    evt[4] = riseEv[4];
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      strobe.wrSel[i] = wrEn && (wrAddr == AW'(regOffset(i)));
      case (regClass(i))
        EV_PORTA:  strobe.commit[i] = evt[0];
        EV_PORTB:  strobe.commit[i] = evt[1];
        EV_UNIT2:  strobe.commit[i] = evt[2];
        EV_WINDOW: strobe.commit[i] = evt[3];
        EV_LINE:   strobe.commit[i] = evt[4];
        default:   strobe.commit[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) staticHazard <= 1'b0;
    else       staticHazard <= strobe.wrSel[0] && procEn;
  end

  // R9
  for (genvar s = 0; s < NSRC; s++) begin : g_pulse_chk
    evt_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
      evt[s] |=> !evt[s]);
  end

  // R3
  hazard_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    staticHazard |=> !staticHazard || $past(wrEn && procEn));
endmodule

// File: rtl/shadow_upload_regs.sv
module shadow_upload_regs
  import shadow_upload_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [DW-1:0]    wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [DW-1:0]    rdData,
  output logic [NREG*DW-1:0] activeFlat,
  output logic [NREG-1:0]  pending,
  output logic [1:0]       edgeSel
);
  logic [DW-1:0] stageQ  [NREG];
  logic [DW-1:0] activeQ [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_static
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[i]  <= '0;
          activeQ[i] <= '0;
        end else if (strobe.wrSel[i]) begin
          stageQ[i]  <= wrData;
          activeQ[i] <= wrData;
        end
      end
      assign pending[i] = 1'b0;
    end else begin : g_shadow
      logic pendQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[i]  <= '0;
          activeQ[i] <= '0;
          pendQ      <= 1'b0;
        end else begin
          if (strobe.commit[i] && pendQ) activeQ[i] <= stageQ[i];
          if (strobe.wrSel[i]) begin
            stageQ[i] <= wrData;
            pendQ     <= 1'b1;
          end else if (strobe.commit[i]) begin
            pendQ <= 1'b0;
          end
        end
      end
      assign pending[i] = pendQ;

      // R9
      active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.commit[i] |=> $stable(activeQ[i]));
      // R11
      pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrSel[i] |=> pendQ);
      // R10
      collide_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.commit[i] && strobe.wrSel[i] && pendQ) |=> activeQ[i] == $past(stageQ[i]));
    end
    assign activeFlat[i*DW +: DW] = activeQ[i];
  end

  assign edgeSel = activeQ[0][1:0];

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NREG; i++)
      if (rdAddr == AW'(regOffset(i))) rdData = stageQ[i];
  end

  // R2
  static_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSel[0] |=> activeQ[0] == $past(wrData));
endmodule

// File: rtl/shadow_upload.sv
module shadow_upload
  import shadow_upload_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               procEn,
  input  logic               wrEn,
  input  logic [AW-1:0]      wrAddr,
  input  logic [DW-1:0]      wrData,
  input  logic [AW-1:0]      rdAddr,
  output logic [DW-1:0]      rdData,
  input  logic               vsA,
  input  logic               vsB,
  input  logic               vGate2,
  input  logic               vGate1,
  input  logic               hGate1,
  output logic [NREG*DW-1:0] activeFlat,
  output logic [NREG-1:0]    pending,
  output logic               evtPortA,
  output logic               evtPortB,
  output logic               evtUnit2Done,
  output logic               evtWindowDone,
  output logic               evtLineDone,
  output logic               staticHazard
);
  strobe_t         strobe;
  logic [NSRC-1:0] evt;
  logic [1:0]      edgeSel;

  shadow_upload_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .procEn(procEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .rawSync({hGate1, vGate1, vGate2, vsB, vsA}), .edgeSel(edgeSel),
    .strobe(strobe), .evt(evt), .staticHazard(staticHazard)
  );

  shadow_upload_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .activeFlat(activeFlat), .pending(pending), .edgeSel(edgeSel)
  );

  assign evtPortA      = evt[0];
  assign evtPortB      = evt[1];
  assign evtUnit2Done  = evt[2];
  assign evtWindowDone = evt[3];
  assign evtLineDone   = evt[4];
endmodule

// File: tb/tb_shadow_upload.sv
module tb_shadow_upload;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NR = 10;

  logic clk = 1'b0, rstN = 1'b0, procEn = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0, rdData;
  logic [4:0] raw = '0;
  logic [NR*DW-1:0] activeFlat;
  logic [NR-1:0] pending;
  logic [4:0] evtOut;
  logic staticHazard;

  int checks = 0, errors = 0;
  logic [DW-1:0] mStage [NR];
  logic [DW-1:0] mAct [NR];
  logic mPend [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_upload #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .procEn(procEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .vsA(raw[0]), .vsB(raw[1]), .vGate2(raw[2]), .vGate1(raw[3]), .hGate1(raw[4]),
    .activeFlat(activeFlat), .pending(pending),
    .evtPortA(evtOut[0]), .evtPortB(evtOut[1]), .evtUnit2Done(evtOut[2]),
    .evtWindowDone(evtOut[3]), .evtLineDone(evtOut[4]), .staticHazard(staticHazard)
  );

  function automatic logic [7:0] offs(int i);
    logic [7:0] t [NR] = '{8'h50, 8'h54, 8'h58, 8'h5C, 8'h60, 8'h64, 8'h68, 8'h6C, 8'h74, 8'h78};
    return t[i];
  endfunction

  // event source feeding each register index: -1 none
  function automatic int srcOf(int i);
    int t [NR] = '{-1, 0, 1, 2, 3, 3, 4, 4, 3, 3};
    return t[i];
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic checkAll(input string tag);
    for (int i = 0; i < NR; i++) begin
      chk(activeFlat[i*DW +: DW] == mAct[i], tag, activeFlat[i*DW +: DW], mAct[i]);
      chk(pending[i] == mPend[i], {tag, " R11 pending"}, DW'(pending[i]), DW'(mPend[i]));
    end
  endtask

  task automatic modelCommit(input int src);
    for (int i = 1; i < NR; i++)
      if (srcOf(i) == src && mPend[i]) begin
        mAct[i] = mStage[i];
        mPend[i] = 1'b0;
      end
  endtask

  function automatic logic edgeHits(input int src, input logic oldV, input logic newV);
    logic wantFall;
    wantFall = (src == 0) ? mAct[0][0] : (src == 1) ? mAct[0][1] : (src == 4) ? 1'b0 : 1'b1;
    return wantFall ? (oldV && !newV) : (!oldV && newV);
  endfunction

  function automatic int idxOf(input logic [7:0] a);
    for (int i = 0; i < NR; i++) if (offs(i) == a) return i;
    return -1;
  endfunction

  task automatic hostWrite(input logic [7:0] a, input logic [DW-1:0] d, input string tag);
    int k;
    k = idxOf(a);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
    if (k == 0) begin
      mStage[0] = d; mAct[0] = d;
      chk(staticHazard == procEn, "R3 hazard after static write", DW'(staticHazard), DW'(procEn));
      tick();
      chk(staticHazard == 1'b0, "R3 hazard one cycle", DW'(staticHazard), 0);
    end else if (k > 0) begin
      mStage[k] = d; mPend[k] = 1'b1;
    end
    checkAll(tag);
  endtask

  task automatic driveSrc(input int src, input logic v, input string tag);
    logic hit;
    hit = edgeHits(src, raw[src], v);
    raw[src] = v;
    tick();
    chk(evtOut[src] == hit, {tag, " R9 event pulse"}, DW'(evtOut[src]), DW'(hit));
    if (hit) modelCommit(src);
    tick();
    chk(evtOut[src] == 1'b0, {tag, " R9 pulse ends"}, DW'(evtOut[src]), 0);
    checkAll(tag);
  endtask

  task automatic testReset();
    for (int i = 0; i < NR; i++) begin mStage[i] = '0; mAct[i] = '0; mPend[i] = 1'b0; end
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    checkAll("R1 reset");
    chk(evtOut == 5'b0 && !staticHazard, "R1 flags", DW'({evtOut, staticHazard}), 0);
    rdAddr = 8'h54; #1;
    chk(rdData == '0, "R1 read zero", rdData, 0);
  endtask

  task automatic testStageAll();
    for (int i = 1; i < NR; i++) hostWrite(offs(i), 32'hA000_0000 + DW'(i), "R11 staged");
    for (int i = 1; i < NR; i++) begin
      rdAddr = offs(i); #1;
      chk(rdData == mStage[i], "R12 read staging", rdData, mStage[i]);
    end
  endtask

  task automatic testEvents();
    driveSrc(4, 1'b1, "R8 line rise");
    driveSrc(4, 1'b0, "R8 line fall ignored");
    driveSrc(3, 1'b1, "R7 window rise ignored");
    driveSrc(3, 1'b0, "R7 window fall");
    driveSrc(2, 1'b1, "R6 unit2 rise ignored");
    driveSrc(2, 1'b0, "R6 unit2 fall");
    driveSrc(0, 1'b1, "R4 portA rise");
    driveSrc(0, 1'b0, "R4 portA fall ignored");
    driveSrc(1, 1'b1, "R5 portB rise");
    driveSrc(1, 1'b0, "R5 portB fall ignored");
  endtask

  task automatic testEdgeSelect();
    procEn = 1'b0;
    hostWrite(8'h50, 32'h0000_0003, "R2 static immediate");
    hostWrite(8'h54, 32'h1111_2222, "R4 restage");
    hostWrite(8'h58, 32'h3333_4444, "R5 restage");
    driveSrc(0, 1'b1, "R4 falling mode rise ignored");
    driveSrc(0, 1'b0, "R4 falling mode commit");
    driveSrc(1, 1'b1, "R5 falling mode rise ignored");
    driveSrc(1, 1'b0, "R5 falling mode commit");
  endtask

  task automatic testCollide();
    hostWrite(8'h68, 32'hCAFE_0001, "R10 first stage");
    raw[4] = 1'b1;
    tick();
    chk(evtOut[4] == 1'b1, "R10 event live", DW'(evtOut[4]), 1);
    wrEn = 1'b1; wrAddr = 8'h68; wrData = 32'hCAFE_0002;
    modelCommit(4);
    mStage[6] = 32'hCAFE_0002; mPend[6] = 1'b1;
    tick();
    wrEn = 1'b0;
    checkAll("R10 collide");
    driveSrc(4, 1'b0, "R10 fall");
    driveSrc(4, 1'b1, "R10 next event");
  endtask

  task automatic testHazardUnmapped();
    procEn = 1'b1;
    hostWrite(8'h50, 32'h0000_0000, "R3 write while running");
    procEn = 1'b0;
    hostWrite(8'h70, 32'hDEAD_BEEF, "R12 unmapped write");
    rdAddr = 8'h70; #1;
    chk(rdData == '0, "R12 unmapped read", rdData, 0);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testStageAll();
    testEvents();
    testEdgeSelect();
    testCollide();
    testHazardUnmapped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule